// File: doc/BRIEF.md
# Smart Card Reset Answer Transmitter

This block picks the card's communication protocol once per power cycle and, when the asynchronous protocol is picked, sends the answer-to-reset characters. At the first card-clock edge after power-on reset is released, it samples the card reset line. A high level, which is what the internal pull-up gives when the host leaves the line alone, selects the synchronous two-wire protocol. A low level selects the asynchronous character protocol. The choice is then held until power is removed.

In asynchronous mode the block waits for the reset line to rise. It then counts a lead-in delay and serialises an 8-byte answer register onto an open-drain I/O line. One bit lasts one elementary time unit (ETU), which is 372 card-clock cycles. In synchronous mode the I/O line is never driven. Instead the block raises a ready flag once the host has given the five clock pulses that must come before the first command.

The controller has these states:
- LS_SELECT: samples the reset line.
- LS_SYNC_WAIT: counts the five pulses.
- LS_SYNC_READY: synchronous mode is ready.
- LS_ASYNC_IDLE: waits for reset to rise.
- LS_LEAD_IN: counts the delay before the first character.
- LS_SENDING: characters are being shifted out.
- LS_FINISHED: the answer is complete.

The transitions are:
- SELECT→SYNC_WAIT when reset is high.
- SELECT→ASYNC_IDLE when reset is low.
- SYNC_WAIT→SYNC_READY on the fifth pulse.
- ASYNC_IDLE→LEAD_IN when reset is sampled high.
- LEAD_IN→SENDING when the delay expires.
- SENDING→FINISHED after the last guard time.
- LEAD_IN, SENDING or FINISHED→ASYNC_IDLE whenever reset is sampled low.

Top module: `atr_link_ctl`

## Requirements
- R1: While `por_n` is low, `io_drive_low`, `mode_valid`, `mode_async`, `sync_ready`, `atr_busy` and `atr_done` are all 0.
- R2: At the first rising clock edge with `por_n` high, `mode_valid` becomes 1. `mode_async` becomes 1 if `card_rst` was low at that edge and 0 if it was high.
- R3: Once `mode_valid` is 1, neither `mode_valid` nor `mode_async` changes until `por_n` goes low, whatever `card_rst` does.
- R4: In synchronous mode, `io_drive_low`, `atr_busy` and `atr_done` stay 0.
- R5: In synchronous mode, `sync_ready` rises after the fifth clock edge that follows the selection edge, and then stays high.
- R6: In asynchronous mode, the first edge that samples `card_rst` high starts the lead-in. The first start bit is driven exactly LEAD_CYCLES (default 400, legal range 400 to 40000) clock cycles after that edge.
- R7: Every transmitted bit lasts exactly ETU_CYCLES (default 372) clock cycles.
- R8: Each character is 12 ETUs long and characters follow one another back to back. A character is a start bit (driven low), 8 data bits LSB first, then one parity bit that makes the count of ones over data plus parity even. It ends with 2 guard ETUs during which the line is released.
- R9: Eight characters are sent. Byte k is `atr_data[8k+7:8k]`, and byte 0 is sent first.
- R10: `atr_busy` is 1 exactly while characters are being sent. `atr_done` is 1 from the end of the last guard time until reset or power-off. `io_drive_low` is 1 only for 0-bits while `atr_busy` is 1.
- R11: In asynchronous mode, sampling `card_rst` low during the lead-in, the transmission or after completion releases the line and clears `atr_busy` and `atr_done` in the next cycle. The next rise restarts the full answer from byte 0 after a fresh lead-in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Card clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| card_rst | input | 1 | Card reset line, sampled on clk |
| atr_data | input | 8*ATR_BYTES | Answer-to-reset register contents, byte 0 in the low bits |
| io_drive_low | output | 1 | 1 pulls the open-drain I/O low, 0 releases it |
| mode_valid | output | 1 | Protocol has been chosen |
| mode_async | output | 1 | 1 = asynchronous character protocol, 0 = synchronous two-wire |
| sync_ready | output | 1 | Synchronous mode has received its five start-up clocks |
| atr_busy | output | 1 | Answer characters are being transmitted |
| atr_done | output | 1 | The full answer has been sent |

## Verification
Three power cycles are run.

- **Reset held high at power-on.** This exercises the synchronous branch. The reset line is then toggled, which shows that a later low level neither switches the mode nor starts a transmission.
- **Reset held low, then released after 400 cycles.** This exercises a complete answer. The answer pattern mixes all-ones, all-zeros, alternating and single-bit bytes, so that bit order, parity polarity and byte order each give a distinct waveform.
- **Reset dropped partway through a character.** This run then raises reset again with a different pattern. It separates a correct restart from byte 0 from a resume at the interrupted position.

// File: rtl/atr_pkg.sv
package atr_pkg;

    typedef enum logic [2:0] {
        LS_SELECT,
        LS_SYNC_WAIT,
        LS_SYNC_READY,
        LS_ASYNC_IDLE,
        LS_LEAD_IN,
        LS_SENDING,
        LS_FINISHED
    } link_state_e;

    localparam int DATA_BITS = 8;

    function automatic logic even_fill(input logic [DATA_BITS-1:0] b);
        return ^b;
    endfunction

endpackage

// File: rtl/proto_latch.sv
module proto_latch (
    input  logic clk,
    input  logic por_n,
    input  logic card_rst,
    output logic mode_valid,
    output logic mode_async
);
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            mode_valid <= 1'b0;
            mode_async <= 1'b0;
        end else if (!mode_valid) begin
            mode_valid <= 1'b1;
            mode_async <= ~card_rst;
        end
    end

    // R3: choice is frozen for the rest of the power cycle
    a_r3_mode_locked: assert property (@(posedge clk) disable iff (!por_n)
        mode_valid |=> (mode_valid && $stable(mode_async)));
endmodule

// File: rtl/etu_frame_gen.sv
module etu_frame_gen #(
    parameter int ETU_CYCLES  = 372,
    parameter int GUARD_ETUS  = 2
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       run,
    input  logic [7:0] byte_in,
    output logic       line_bit,
    output logic       char_end
);
    import atr_pkg::*;

    localparam int FRAME_ETUS = 1 + DATA_BITS + 1 + GUARD_ETUS;
    localparam int CNT_W = $clog2(ETU_CYCLES);
    localparam int IDX_W = $clog2(FRAME_ETUS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ETU_CYCLES - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_ETUS - 1);
    localparam logic [IDX_W-1:0] IDX_PAR  = IDX_W'(DATA_BITS + 1);

    logic [CNT_W-1:0] etu_cnt;
    logic [IDX_W-1:0] bit_idx;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            etu_cnt <= '0;
            bit_idx <= '0;
        end else if (!run) begin
            etu_cnt <= '0;
            bit_idx <= '0;
        end else if (etu_cnt == CNT_LAST) begin
            etu_cnt <= '0;
            bit_idx <= (bit_idx == IDX_LAST) ? '0 : bit_idx + 1'b1;
        end else begin
            etu_cnt <= etu_cnt + 1'b1;
        end
    end

    always_comb begin
        if (bit_idx == '0)
            line_bit = 1'b0;
        else if (bit_idx < IDX_PAR)
            line_bit = byte_in[3'(bit_idx - 1'b1)];
        else if (bit_idx == IDX_PAR)
            line_bit = even_fill(byte_in);
        else
            line_bit = 1'b1;
    end

    assign char_end = run && (etu_cnt == CNT_LAST) && (bit_idx == IDX_LAST);

    // R7: a bit value holds for the whole ETU
    a_r7_bit_hold: assert property (@(posedge clk) disable iff (!por_n)
        (run && etu_cnt != '0) |-> $stable(line_bit));
endmodule

// File: rtl/atr_link_ctl.sv
module atr_link_ctl #(
    parameter int ATR_BYTES   = 8,
    parameter int ETU_CYCLES  = 372,
    parameter int LEAD_CYCLES = 400,
    parameter int SYNC_PULSES = 5,
    parameter int GUARD_ETUS  = 2
) (
    input  logic                   clk,
    input  logic                   por_n,
    input  logic                   card_rst,
    input  logic [8*ATR_BYTES-1:0] atr_data,
    output logic                   io_drive_low,
    output logic                   mode_valid,
    output logic                   mode_async,
    output logic                   sync_ready,
    output logic                   atr_busy,
    output logic                   atr_done
);
    import atr_pkg::*;

    localparam int LEAD_W = $clog2(LEAD_CYCLES + 1);
    localparam int SYNC_W = $clog2(SYNC_PULSES + 1);
    localparam int BYTE_W = (ATR_BYTES > 1) ? $clog2(ATR_BYTES) : 1;
    localparam logic [LEAD_W-1:0] LEAD_LAST = LEAD_W'(LEAD_CYCLES - 1);
    localparam logic [SYNC_W-1:0] SYNC_LAST = SYNC_W'(SYNC_PULSES - 1);
    localparam logic [BYTE_W-1:0] BYTE_LAST = BYTE_W'(ATR_BYTES - 1);

    link_state_e      state;
    logic [LEAD_W-1:0] lead_cnt;
    logic [SYNC_W-1:0] sync_cnt;
    logic [BYTE_W-1:0] byte_idx;
    logic [7:0]        cur_byte;
    logic              line_bit;
    logic              char_end;
    logic              sending;

    proto_latch u_mode (
        .clk        (clk),
        .por_n      (por_n),
        .card_rst   (card_rst),
        .mode_valid (mode_valid),
        .mode_async (mode_async)
    );

    assign cur_byte = atr_data[8*int'(byte_idx) +: 8];

    etu_frame_gen #(
        .ETU_CYCLES (ETU_CYCLES),
        .GUARD_ETUS (GUARD_ETUS)
    ) u_frame (
        .clk      (clk),
        .por_n    (por_n),
        .run      (sending),
        .byte_in  (cur_byte),
        .line_bit (line_bit),
        .char_end (char_end)
    );

    // State register and counters
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state    <= LS_SELECT;
            lead_cnt <= '0;
            sync_cnt <= '0;
            byte_idx <= '0;
        end else begin
            unique case (state)
                LS_SELECT: begin
                    sync_cnt <= '0;
                    state    <= card_rst ? LS_SYNC_WAIT : LS_ASYNC_IDLE;
                end
                LS_SYNC_WAIT: begin
                    sync_cnt <= sync_cnt + 1'b1;
                    if (sync_cnt == SYNC_LAST) state <= LS_SYNC_READY;
                end
                LS_SYNC_READY: state <= LS_SYNC_READY;
                LS_ASYNC_IDLE: begin
                    lead_cnt <= '0;
                    byte_idx <= '0;
                    if (card_rst) state <= LS_LEAD_IN;
                end
                LS_LEAD_IN: begin
                    if (!card_rst)
                        state <= LS_ASYNC_IDLE;
                    else if (lead_cnt == LEAD_LAST)
                        state <= LS_SENDING;
                    else
                        lead_cnt <= lead_cnt + 1'b1;
                end
                LS_SENDING: begin
                    if (!card_rst)
                        state <= LS_ASYNC_IDLE;
                    else if (char_end) begin
                        if (byte_idx == BYTE_LAST) state <= LS_FINISHED;
                        else byte_idx <= byte_idx + 1'b1;
                    end
                end
                LS_FINISHED: if (!card_rst) state <= LS_ASYNC_IDLE;
                default: state <= LS_SELECT;
            endcase
        end
    end

    // Outputs
    always_comb begin
        sending      = (state == LS_SENDING);
        atr_busy     = sending;
        atr_done     = (state == LS_FINISHED);
        sync_ready   = (state == LS_SYNC_READY);
        io_drive_low = sending && !line_bit;
    end

    // R4: synchronous mode never touches the line
    a_r4_sync_silent: assert property (@(posedge clk) disable iff (!por_n)
        (mode_valid && !mode_async) |-> (!io_drive_low && !atr_busy && !atr_done));

    // R8: every transmission opens with a start bit
    a_r8_start_first: assert property (@(posedge clk) disable iff (!por_n)
        $rose(atr_busy) |-> io_drive_low);

    // R10: line released once the answer is complete
    a_r10_done_released: assert property (@(posedge clk) disable iff (!por_n)
        atr_done |-> (!io_drive_low && !atr_busy));

    // R11: reset low aborts at once
    a_r11_abort_release: assert property (@(posedge clk) disable iff (!por_n)
        (mode_valid && mode_async && !card_rst) |=> (!io_drive_low && !atr_busy && !atr_done));

    // R5: ready only in synchronous mode
    a_r5_ready_sync_only: assert property (@(posedge clk) disable iff (!por_n)
        sync_ready |-> (mode_valid && !mode_async));
endmodule

// File: tb/sim_atr_link_ctl.sv
module sim_atr_link_ctl;
    localparam int CLK_PERIOD = 10;
    localparam int NB   = 8;
    localparam int ETU  = 372;
    localparam int LEAD = 400;
    localparam int CHAR = 12 * ETU;
    localparam int TOTAL = NB * CHAR;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic card_rst = 1'b1;
    logic [8*NB-1:0] atr_data = 64'h96_01_7E_81_3C_FF_00_A5;
    logic io_drive_low, mode_valid, mode_async, sync_ready, atr_busy, atr_done;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    atr_link_ctl u0 (
        .clk(clk), .por_n(por_n), .card_rst(card_rst), .atr_data(atr_data),
        .io_drive_low(io_drive_low), .mode_valid(mode_valid), .mode_async(mode_async),
        .sync_ready(sync_ready), .atr_busy(atr_busy), .atr_done(atr_done));

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
        end
    endtask

    // Behavioural reference: 0 unchosen, 1 sync, 2 async
    int m_mode = 0;
    int m_sync = 0;
    int m_ph = 0; // 0 wait, 1 lead, 2 send, 3 done
    int m_t = 0;

    always @(posedge clk) begin
        if (!por_n) begin
            m_mode = 0; m_sync = 0; m_ph = 0; m_t = 0;
        end else if (m_mode == 0) begin
            m_mode = card_rst ? 1 : 2;
            m_sync = 0; m_ph = 0; m_t = 0;
        end else if (m_mode == 1) begin
            if (m_sync < 5) m_sync++;
        end else if (!card_rst) begin
            m_ph = 0; m_t = 0;
        end else begin
            case (m_ph)
                0: begin m_ph = 1; m_t = 0; end
                1: if (m_t == LEAD - 1) begin m_ph = 2; m_t = 0; end else m_t++;
                2: if (m_t == TOTAL - 1) begin m_ph = 3; m_t = 0; end else m_t++;
                default: ;
            endcase
        end
    end

    function automatic bit exp_level(input int t, output string req);
        int ch, b;
        logic [7:0] by;
        ch = t / CHAR;
        b  = (t / ETU) % 12;
        by = atr_data[8*ch +: 8];
        if (b == 0) begin req = "R8"; return 1'b0; end
        if (b <= 8) begin req = "R9"; return by[b-1]; end
        req = "R8";
        if (b == 9) return ^by;
        return 1'b1;
    endfunction

    always @(negedge clk) begin
        #1;
        if (!por_n) begin
            chk(!io_drive_low && !mode_valid && !mode_async && !sync_ready && !atr_busy && !atr_done,
                "R1", {mode_valid, mode_async, sync_ready, atr_busy, atr_done, io_drive_low}, 0);
        end else begin
            string rq;
            bit lvl;
            chk(mode_valid == (m_mode != 0), "R2", mode_valid, m_mode != 0);
            chk(mode_async == (m_mode == 2), "R3", mode_async, m_mode == 2);
            chk(sync_ready == (m_mode == 1 && m_sync >= 5), "R5", sync_ready, m_mode == 1 && m_sync >= 5);
            chk(atr_busy == (m_mode == 2 && m_ph == 2), "R10", atr_busy, m_mode == 2 && m_ph == 2);
            chk(atr_done == (m_mode == 2 && m_ph == 3), "R10", atr_done, m_mode == 2 && m_ph == 3);
            if (m_mode == 2 && m_ph == 2) begin
                lvl = exp_level(m_t, rq);
                chk(io_drive_low == !lvl, rq, io_drive_low, !lvl);
            end else begin
                chk(!io_drive_low, (m_mode == 1) ? "R4" : "R11", io_drive_low, 0);
            end
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int cnt;
        // Session 1: synchronous
        por_n = 1'b0; card_rst = 1'b1;
        cycles(3);
        chk(!mode_valid && !io_drive_low, "R1", mode_valid, 0);
        por_n = 1'b1;
        cycles(1);
        chk(mode_valid && !mode_async, "R2", mode_async, 0);
        cycles(4);
        chk(!sync_ready, "R5", sync_ready, 0);
        cycles(1);
        chk(sync_ready, "R5", sync_ready, 1);
        for (int i = 0; i < 6; i++) begin
            card_rst = ~card_rst;
            cycles(7);
        end
        card_rst = 1'b0;
        cycles(450);
        chk(!mode_async && !atr_busy && !io_drive_low, "R4", {mode_async, atr_busy}, 0);
        chk(sync_ready, "R3", sync_ready, 1);

        // Session 2: asynchronous, full answer
        por_n = 1'b0; card_rst = 1'b0;
        cycles(2);
        por_n = 1'b1;
        cycles(1);
        chk(mode_valid && mode_async, "R2", mode_async, 1);
        cycles(399);
        card_rst = 1'b1;
        cnt = 0;
        while (!io_drive_low && cnt < 50000) begin cycles(1); cnt++; end
        chk(cnt - 1 == LEAD, "R6", cnt - 1, LEAD);
        cnt = 0;
        while (io_drive_low && cnt < 5000) begin cycles(1); cnt++; end
        chk(cnt == ETU, "R7", cnt, ETU);
        while (!atr_done && cnt < 100000) begin cycles(1); cnt++; end
        chk(atr_done && !atr_busy, "R10", atr_done, 1);
        card_rst = 1'b0;
        cycles(1);
        chk(!atr_done && mode_async, "R11", atr_done, 0);

        // Session 3: abort mid-character, restart with new pattern
        por_n = 1'b0;
        cycles(2);
        por_n = 1'b1;
        cycles(400);
        card_rst = 1'b1;
        cycles(LEAD + 2 * CHAR + 5 * ETU + 17);
        chk(atr_busy, "R10", atr_busy, 1);
        card_rst = 1'b0;
        cycles(1);
        chk(!atr_busy && !io_drive_low, "R11", atr_busy, 0);
        atr_data = 64'h00_80_55_AA_F0_0F_C3_5B;
        cycles(100);
        card_rst = 1'b1;
        cycles(LEAD + TOTAL + 20);
        chk(atr_done, "R9", atr_done, 1);
        chk(mode_async, "R3", mode_async, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule